// File: doc/BRIEF.md
# Debug Command PC-Sync Trace Unit

This block sits behind a host debug front end and acts on 8-bit command opcodes, each offered with a one-cycle valid strobe. It acts on three opcodes and ignores all others. Two of them are status reads. Each returns the top byte of one of two control/status words as a single response byte.

The third opcode is a program-counter synchronization request. It never halts the core. The block raises a request to the core and waits for an instruction-complete strobe. It then places a taken-branch code on the 4-bit processor-status bus. In the next cycle it places a length marker on that bus. After that it streams the captured next-PC address, one nibble per clock, on a 4-bit data bus.

A bit in the main control/status word chooses whether the address is 2 bytes or 3 bytes long. A trace collector can use the resulting stream as a point where the instruction flow lines up with a known PC.

Top module: `dbg_pcsync_trace`

## Requirements
- R1: When `cmd_valid` is high with opcode 0x2E, `rsp_valid` is high in the next cycle and `rsp_byte` equals `csr2[31:24]`.
- R2: When `cmd_valid` is high with opcode 0x2F, `rsp_valid` is high in the next cycle and `rsp_byte` equals `csr3[31:24]`.
- R3: Any other opcode, including 0x01, gives no response: `rsp_valid` stays low and `rsp_byte` reads 0. An opcode other than 0x01 also starts no trace activity.
- R4: Opcode 0x01, accepted while idle, makes `core_sync_req` high from the next cycle. The request holds until a cycle in which `core_insn_done` is high.
- R5: When `core_insn_done` is high while the request is raised, `pst` shows 0x5 in the next cycle and `core_sync_req` drops. `core_next_pc` is captured at that same clock edge.
- R6: In the cycle after the 0x5 code, `pst` shows 0x9 if `csr_main[9]` was 0 at the capture edge, or 0xA if it was 1.
- R7: Starting in the cycle after the marker, `ddata` carries the captured address one nibble per cycle, least significant nibble first. It runs for 4 cycles in 2-byte mode and 6 cycles in 3-byte mode.
- R8: In every cycle other than the branch and marker cycles, `pst` is 0x0. Outside the streaming cycles, `ddata` is 0x0.
- R9: A 0x01 opcode that arrives while a synchronization is pending or streaming is ignored. Status reads are still answered during that time.
- R10: `core_insn_done` has no effect while no request is pending.
- R11: A synchronous active-low reset (`rst_n` low at a clock edge) clears the pending request and any stream. It returns `pst`, `ddata`, `rsp_valid` and `core_sync_req` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Opcode strobe from the host front end |
| cmd_byte | input | 8 | Command opcode |
| csr_main | input | 32 | Main control/status word; bit 9 selects the address length |
| csr2 | input | 32 | Second control/status word |
| csr3 | input | 32 | Third control/status word |
| rsp_valid | output | 1 | Response byte valid |
| rsp_byte | output | 8 | Response byte to the host |
| core_sync_req | output | 1 | PC synchronization pending, to the core |
| core_insn_done | input | 1 | Core has completed its current instruction |
| core_next_pc | input | 24 | Address of the forced fetch |
| pst | output | 4 | Processor-status code |
| ddata | output | 4 | Debug-data nibble |

## Verification
A status read's response is due exactly one cycle after the opcode is strobed. The request line is due one cycle after a 0x01. The branch code is due one cycle after the completion strobe, and the marker one cycle after that. The first address nibble follows in the next cycle, and one more nibble follows each cycle after it. The bench drives every input on the falling clock edge. It then compares the outputs on the next falling edge, so each comparison sees the state left by exactly one rising edge. The bench counts edges one by one through a synchronization sequence and checks every cycle of it. Injected commands land on known cycles of the pending and streaming phases.

// File: rtl/dbg_pkg.sv
// Package: shared opcodes, status codes and state type of the PC-sync trace unit.
// Assumes 4-bit status and data buses.
package dbg_pkg;
    localparam logic [7:0] OP_SYNC_PC  = 8'h01;
    localparam logic [7:0] OP_RD_CSR2  = 8'h2E;
    localparam logic [7:0] OP_RD_CSR3  = 8'h2F;

    localparam logic [3:0] PST_CONT    = 4'h0;
    localparam logic [3:0] PST_BRANCH  = 4'h5;
    localparam logic [3:0] PST_MARK2   = 4'h9;
    localparam logic [3:0] PST_MARK3   = 4'hA;

    typedef enum logic [2:0] {
        SY_IDLE,
        SY_PEND,
        SY_BRANCH,
        SY_MARK,
        SY_STREAM
    } sync_state_t;
endpackage

// File: rtl/dbg_cmd_decode.sv
// Module: dbg_cmd_decode
// Decodes host opcodes. Answers the two status reads with a registered byte
// one cycle after acceptance and flags a sync request in the same cycle.
// Assumes one opcode per valid cycle and no back-pressure toward the host.
module dbg_cmd_decode
    import dbg_pkg::*;
#(
    parameter int CMD_W = 8,
    parameter int RSP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_byte,
    input  logic [RSP_W-1:0] csr2_top,
    input  logic [RSP_W-1:0] csr3_top,
    output logic             rsp_valid,
    output logic [RSP_W-1:0] rsp_byte,
    output logic             sync_start
);
    logic rd2, rd3;

    // Opcode match decode.
    always_comb begin
        rd2        = cmd_valid && (cmd_byte == OP_RD_CSR2);
        rd3        = cmd_valid && (cmd_byte == OP_RD_CSR3);
        sync_start = cmd_valid && (cmd_byte == OP_SYNC_PC);
    end

    // Register the read response; the byte is zero whenever not valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_byte  <= '0;
        end else begin
            rsp_valid <= rd2 || rd3;
            rsp_byte  <= rd2 ? csr2_top : (rd3 ? csr3_top : '0);
        end
    end

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_byte == OP_RD_CSR2 || cmd_byte == OP_RD_CSR3)) |=> rsp_valid); // R1
    AST_RSP_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cmd_valid)); // R3
endmodule

// File: rtl/dbg_addr_shift.sv
// Module: dbg_addr_shift
// Holds the captured PC and shifts it right one nibble per shift strobe.
// The lowest nibble is always presented. Assumes PC_W is a multiple of NIB_W.
module dbg_addr_shift #(
    parameter int PC_W  = 24,
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [PC_W-1:0]  din,
    output logic [NIB_W-1:0] nib
);
    logic [PC_W-1:0] sh_q;

    // Load on capture, then shift down a nibble per streamed cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     sh_q <= '0;
        else if (load)  sh_q <= din;
        else if (shift) sh_q <= sh_q >> NIB_W;
    end

    assign nib = sh_q[NIB_W-1:0];
endmodule

// File: rtl/dbg_sync_fsm.sv
// Module: dbg_sync_fsm
// Sequences a PC synchronization: pending request, branch code, length
// marker, then a nibble stream of 2- or 3-byte length. Start requests are
// taken only while idle. Assumes the core strobes completion for one cycle.
module dbg_sync_fsm
    import dbg_pkg::*;
#(
    parameter int PC_W  = 24,
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_start,
    input  logic             insn_done,
    input  logic             long_sel,
    output logic             sync_req,
    output logic             load,
    output logic             shift,
    output logic             streaming,
    output logic [NIB_W-1:0] pst
);
    localparam int LONG_NIB  = PC_W / NIB_W;
    localparam int SHORT_NIB = 16 / NIB_W;
    localparam int CNT_W     = $clog2(LONG_NIB + 1);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_NIB - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_NIB - 1);

    sync_state_t     st_q;
    logic            long_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_idx;

    assign last_idx = long_q ? LAST_LONG : LAST_SHORT;

    // Sequence state, length flag and nibble counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SY_IDLE;
            long_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            case (st_q)
                SY_IDLE:   if (sync_start) st_q <= SY_PEND;
                SY_PEND:   if (insn_done) begin
                               st_q   <= SY_BRANCH;
                               long_q <= long_sel;
                           end
                SY_BRANCH: st_q <= SY_MARK;
                SY_MARK:   begin
                               st_q  <= SY_STREAM;
                               cnt_q <= '0;
                           end
                SY_STREAM: if (cnt_q == last_idx) st_q <= SY_IDLE;
                           else                   cnt_q <= cnt_q + 1'b1;
                default:   st_q <= SY_IDLE;
            endcase
        end
    end

    // Output decode from state.
    always_comb begin
        sync_req  = (st_q == SY_PEND);
        load      = (st_q == SY_PEND) && insn_done;
        streaming = (st_q == SY_STREAM);
        shift     = streaming;
        case (st_q)
            SY_BRANCH: pst = PST_BRANCH;
            SY_MARK:   pst = long_q ? PST_MARK3 : PST_MARK2;
            default:   pst = PST_CONT;
        endcase
    end

    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_req && !insn_done) |=> sync_req); // R4
    AST_BRANCH_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_req && insn_done) |=> (pst == PST_BRANCH)); // R5
    AST_MARK_AFTER_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (pst == PST_BRANCH) |=> (pst == PST_MARK2 || pst == PST_MARK3)); // R6
endmodule

// File: rtl/dbg_pcsync_trace.sv
// Module: dbg_pcsync_trace (top)
// Debug command handler for two status reads and a non-intrusive PC
// synchronization. The synchronization is traced on a 4-bit status bus and a
// 4-bit data bus. Assumes the core stub holds core_next_pc valid while it
// strobes core_insn_done.
module dbg_pcsync_trace
    import dbg_pkg::*;
#(
    parameter int PC_W    = 24,
    parameter int NIB_W   = 4,
    parameter int CSR_W   = 32,
    parameter int LEN_BIT = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_byte,
    input  logic [CSR_W-1:0] csr_main,
    input  logic [CSR_W-1:0] csr2,
    input  logic [CSR_W-1:0] csr3,
    output logic             rsp_valid,
    output logic [7:0]       rsp_byte,
    output logic             core_sync_req,
    input  logic             core_insn_done,
    input  logic [PC_W-1:0]  core_next_pc,
    output logic [NIB_W-1:0] pst,
    output logic [NIB_W-1:0] ddata
);
    localparam int TOP_LO = CSR_W - 8;

    logic             sync_start, load, shift, streaming;
    logic [NIB_W-1:0] nib;

    dbg_cmd_decode #(.CMD_W(8), .RSP_W(8)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_byte   (cmd_byte),
        .csr2_top   (csr2[CSR_W-1:TOP_LO]),
        .csr3_top   (csr3[CSR_W-1:TOP_LO]),
        .rsp_valid  (rsp_valid),
        .rsp_byte   (rsp_byte),
        .sync_start (sync_start)
    );

    dbg_sync_fsm #(.PC_W(PC_W), .NIB_W(NIB_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_start (sync_start),
        .insn_done  (core_insn_done),
        .long_sel   (csr_main[LEN_BIT]),
        .sync_req   (core_sync_req),
        .load       (load),
        .shift      (shift),
        .streaming  (streaming),
        .pst        (pst)
    );

    dbg_addr_shift #(.PC_W(PC_W), .NIB_W(NIB_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .shift (shift),
        .din   (core_next_pc),
        .nib   (nib)
    );

    // Data bus carries a nibble only while streaming.
    assign ddata = streaming ? nib : '0;

    AST_DDATA_QUIET_ON_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (pst != PST_CONT) |-> (ddata == '0)); // R8
endmodule

// File: tb/dbg_pcsync_trace_test.sv
module dbg_pcsync_trace_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    // {opcode, csr2 top, csr3 top, expected valid, expected byte}
    localparam logic [39:0] VEC [NV] = '{
        {8'h2E, 8'hA5, 8'h3C, 8'h01, 8'hA5},
        {8'h2F, 8'hA5, 8'h3C, 8'h01, 8'h3C},
        {8'h2E, 8'h00, 8'hFF, 8'h01, 8'h00},
        {8'h2F, 8'h12, 8'h81, 8'h01, 8'h81},
        {8'h2D, 8'h77, 8'h66, 8'h00, 8'h00},
        {8'h01, 8'h77, 8'h66, 8'h00, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = '0;
    logic [31:0] csr_main = '0, csr2 = '0, csr3 = '0;
    logic        rsp_valid, core_sync_req;
    logic [7:0]  rsp_byte;
    logic        core_insn_done = 1'b0;
    logic [23:0] core_next_pc = '0;
    logic [3:0]  pst, ddata;
    int          n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_pcsync_trace uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .csr_main(csr_main), .csr2(csr2), .csr3(csr3),
        .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .core_sync_req(core_sync_req),
        .core_insn_done(core_insn_done), .core_next_pc(core_next_pc),
        .pst(pst), .ddata(ddata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle_check(input string req);
        chk(req, {28'd0, pst}, 32'h0);
        chk(req, {28'd0, ddata}, 32'h0);
        chk(req, {31'd0, core_sync_req}, 32'h0);
    endtask

    // Full sync sequence; optional injections during pending and streaming.
    task automatic do_sync(input logic [23:0] pc, input logic long_mode, input logic inject);
        int n;
        n = long_mode ? 6 : 4;
        csr_main[9] = long_mode;
        cmd_byte = 8'h01; cmd_valid = 1'b1;
        tick();
        cmd_valid = 1'b0;
        chk("R4 req raised", {31'd0, core_sync_req}, 32'h1);
        chk("R8 pst idle while pending", {28'd0, pst}, 32'h0);
        if (inject) begin cmd_byte = 8'h01; cmd_valid = 1'b1; end
        tick();
        cmd_valid = 1'b0;
        chk("R4 req held", {31'd0, core_sync_req}, 32'h1);
        core_insn_done = 1'b1; core_next_pc = pc;
        tick();
        core_insn_done = 1'b0; core_next_pc = 24'hDEAD00;
        csr_main[9] = ~long_mode;
        chk("R5 branch code", {28'd0, pst}, 32'h5);
        chk("R5 req dropped", {31'd0, core_sync_req}, 32'h0);
        chk("R8 ddata zero on branch", {28'd0, ddata}, 32'h0);
        tick();
        chk("R6 marker", {28'd0, pst}, long_mode ? 32'hA : 32'h9);
        for (int i = 0; i < n; i++) begin
            tick();
            cmd_valid = 1'b0;
            if (inject && i == 1) begin
                chk("R9 read during stream valid", {31'd0, rsp_valid}, 32'h1);
                chk("R9 read during stream byte", {24'd0, rsp_byte}, {24'd0, csr2[31:24]});
            end
            chk("R7 nibble", {28'd0, ddata}, {28'd0, pc[4*i +: 4]});
            chk("R8 pst continue while streaming", {28'd0, pst}, 32'h0);
            if (inject && i == 0) begin cmd_byte = 8'h2E; cmd_valid = 1'b1; end
            if (inject && i == 2) begin cmd_byte = 8'h01; cmd_valid = 1'b1; end
        end
        tick();
        cmd_valid = 1'b0;
        idle_check("R7 stream ends");
        tick();
        idle_check("R9 second sync ignored");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(); tick();
        idle_check("R11 reset state");
        chk("R11 reset rsp", {31'd0, rsp_valid}, 32'h0);
        rst_n = 1'b1;
        tick();

        // Table walk: status reads and non-responding opcodes (R1 R2 R3).
        for (int v = 0; v < NV; v++) begin
            cmd_byte = VEC[v][39:32];
            csr2 = {VEC[v][31:24], 24'h5A5A5A};
            csr3 = {VEC[v][23:16], 24'hC3C3C3};
            cmd_valid = 1'b1;
            tick();
            cmd_valid = 1'b0;
            chk("R1/R2/R3 rsp_valid", {31'd0, rsp_valid}, {31'd0, VEC[v][8]});
            chk("R1/R2/R3 rsp_byte", {24'd0, rsp_byte}, {24'd0, VEC[v][7:0]});
            if (VEC[v][39:32] == 8'h01) begin
                tick(); core_insn_done = 1'b1; core_next_pc = 24'h000123;
                tick(); core_insn_done = 1'b0; tick(); tick();
                for (int k = 0; k < 6; k++) tick();
            end else begin
                chk("R3 no trace", {28'd0, pst}, 32'h0);
                chk("R3 no request", {31'd0, core_sync_req}, 32'h0);
            end
        end
        tick();

        // R10: completion strobe without a pending request.
        core_insn_done = 1'b1; core_next_pc = 24'h111111;
        tick();
        core_insn_done = 1'b0;
        idle_check("R10 done ignored");
        tick();
        idle_check("R10 done ignored later");

        do_sync(24'hABCDEF, 1'b0, 1'b0);
        do_sync(24'h987654, 1'b1, 1'b0);
        csr2 = 32'h6E000000;
        do_sync(24'h13579B, 1'b0, 1'b1);

        // R11: reset in mid-stream.
        csr_main[9] = 1'b1;
        cmd_byte = 8'h01; cmd_valid = 1'b1;
        tick(); cmd_valid = 1'b0;
        core_insn_done = 1'b1; core_next_pc = 24'hFEDCBA;
        tick(); core_insn_done = 1'b0;
        tick(); tick();
        chk("R11 streaming before reset", {28'd0, ddata}, 32'hA);
        rst_n = 1'b0;
        tick();
        idle_check("R11 reset clears stream");
        rst_n = 1'b1;
        tick();
        idle_check("R11 idle after reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule